// File: doc/BRIEF.md
# Zeroizing Hash Message Register Bank

This block is a small register bank that a processor fills over an AXI4-Lite slave port before handing the contents to a hash engine. Software writes a 512-bit message block as sixteen 32-bit words, then sets a go bit in a control register. The bank then presents the block to the engine together with a one-cycle start strobe. It freezes the words while the engine works, and waits for the engine's result-valid signal.

On the rising edge of result-valid the bank wipes every message word and every word-loaded flag to zero in the same clock. Plaintext therefore cannot be read back over the bus between one hash and the next. An active-low global reset and an active-high peripheral reset both also clear the bank. Both resets are sampled on the clock.

The sequencer has three states:
- `SQ_IDLE` is the bus-owned state. It moves to `SQ_LAUNCH` when a go-bit write is accepted while all sixteen words are loaded and no wipe happens in that cycle.
- `SQ_LAUNCH` drives the start strobe. It always moves to `SQ_WAIT` on the next clock.
- `SQ_WAIT` holds the block steady. It returns to `SQ_IDLE` on the rising edge of result-valid.

Top module: `hscrub_bank`

## Requirements
- R1: Message word k (k = 0..15) sits at byte address 4*k and reads back what was written. Each set bit i of the write strobe replaces byte i (bits 8i+7..8i) of the word. All words read 0 after reset.
- R2: While `rst_n` is low or `periph_rst` is high at a clock edge, all message words, loaded flags, the done flag and the sequencer are cleared.
- R3: A write with bit 0 set to the control address 0x40 starts a hash only if three conditions hold: the bank is idle, all sixteen words have been written since the last clear, and no wipe occurs in that cycle. `eng_start` is then high for exactly the one cycle after the write is accepted. A go request that does not meet these conditions gets OKAY and produces no strobe.
- R4: While busy, `eng_block` carries word k on bits 32k+31..32k. While idle, `eng_block` is zero.
- R5: The status address 0x44 reads bit 0 = busy, bit 1 = done and bit 2 = all words loaded; the other bits are 0. Busy runs from the cycle after an accepted start until the rising edge of result-valid. Done is set by a wipe and cleared by a start.
- R6: A clock edge where `eng_result_valid` is high and was low at the previous edge clears all sixteen words and their loaded flags, and sets done. Every message read afterwards returns 0x00000000 until that word is written again.
- R7: If a message write is accepted in the same cycle as a wipe, the wipe wins and the word reads 0 afterwards.
- R8: While busy, writes to message words or to the control register get OKAY and change nothing.
- R9: The following accesses get SLVERR (2'b10) and change no state: a word index of 18 or more, a byte address with nonzero low two bits, and a write to the status address. A read of any of these returns 0. The control register reads 0 with OKAY.
- R10: A write is accepted in a cycle where `s_awvalid` and `s_wvalid` are both high and no write response is pending. A read is accepted when `s_arvalid` is high and no read response is pending. Each response appears the cycle after acceptance and holds, stable, until it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Global reset, active low, synchronous |
| periph_rst | input | 1 | Peripheral reset, active high, synchronous |
| s_awaddr | input | 7 | Write address (byte) |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 7 | Read address (byte) |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read response valid |
| s_rready | input | 1 | Read response ready |
| eng_block | output | 512 | Message block to the hash engine |
| eng_start | output | 1 | One-cycle start strobe |
| eng_result_valid | input | 1 | Engine result valid |

## Verification
The assertions watch the following on every cycle:
- the start strobe never lasts two cycles, and it follows a cycle in which the bank was fully loaded;
- every rising edge of result-valid leaves all words and loaded flags at zero, including when a bus write lands in that same cycle;
- the block stays stable through a busy period;
- both bus responses hold until they are taken.

Only the bench's scenarios can show the remaining behaviour:
- that a read after a wipe returns zero rather than stale data;
- that refused go requests, misaligned or unmapped accesses and status writes leave nothing changed;
- that either reset clears the words.

The bench shows these by comparing the ports every clock against a behavioural model.

// File: rtl/hscrub_pkg.sv
package hscrub_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_LAUNCH = 2'd1,
        SQ_WAIT   = 2'd2
    } seq_state_t;

    localparam logic [1:0] RESP_OKAY   = 2'b00;
    localparam logic [1:0] RESP_SLVERR = 2'b10;
endpackage

// File: rtl/hscrub_axil_port.sv
module hscrub_axil_port
    import hscrub_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 7,
    parameter int NUM_WORDS = 16,
    localparam int IDX_W    = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              awvalid,
    output logic              awready,
    input  logic              wvalid,
    output logic              wready,
    output logic [1:0]        bresp,
    output logic              bvalid,
    input  logic              bready,
    input  logic [ADDR_W-1:0] araddr,
    input  logic              arvalid,
    output logic              arready,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        rresp,
    output logic              rvalid,
    input  logic              rready,
    input  logic [DATA_W-1:0] rd_word,
    output logic              wr_fire,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [IDX_W-1:0]  rd_idx
);
    localparam logic [IDX_W-1:0] CTRL_IDX = IDX_W'(NUM_WORDS);
    localparam logic [IDX_W-1:0] STAT_IDX = IDX_W'(NUM_WORDS + 1);

    logic wr_take, rd_take, wr_ok, rd_ok;

    assign wr_idx  = awaddr[ADDR_W-1:2];
    assign rd_idx  = araddr[ADDR_W-1:2];
    assign wr_ok   = (awaddr[1:0] == 2'b00) && (wr_idx <= CTRL_IDX);
    assign rd_ok   = (araddr[1:0] == 2'b00) && (rd_idx <= STAT_IDX);
    assign wr_take = awvalid && wvalid && !bvalid;
    assign rd_take = arvalid && !rvalid;
    assign awready = wr_take;
    assign wready  = wr_take;
    assign arready = !rvalid;
    assign wr_fire = wr_take && wr_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            bvalid <= 1'b0;
            bresp  <= RESP_OKAY;
        end else if (wr_take) begin
            bvalid <= 1'b1;
            bresp  <= wr_ok ? RESP_OKAY : RESP_SLVERR;
        end else if (bready) begin
            bvalid <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
            rdata  <= '0;
            rresp  <= RESP_OKAY;
        end else if (rd_take) begin
            rvalid <= 1'b1;
            rdata  <= rd_ok ? rd_word : '0;
            rresp  <= rd_ok ? RESP_OKAY : RESP_SLVERR;
        end else if (rready) begin
            rvalid <= 1'b0;
        end
    end

    // R10
    bresp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bvalid && !bready) |=> (bvalid && $stable(bresp)));
    // R10
    rresp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rvalid && !rready) |=> (rvalid && $stable(rdata) && $stable(rresp)));
endmodule

// File: rtl/hscrub_seq.sv
module hscrub_seq
    import hscrub_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ctrl_go,
    input  logic all_loaded,
    input  logic res_valid,
    output logic eng_start,
    output logic busy,
    output logic done,
    output logic zeroize
);
    seq_state_t st, st_nx;
    logic valid_q, launch;

    always_ff @(posedge clk) begin
        if (rst) valid_q <= 1'b0;
        else     valid_q <= res_valid;
    end

    assign zeroize = res_valid && !valid_q;
    assign launch  = (st == SQ_IDLE) && ctrl_go && all_loaded && !zeroize;

    always_comb begin
        st_nx = st;
        unique case (st)
            SQ_IDLE:   if (launch)  st_nx = SQ_LAUNCH;
            SQ_LAUNCH:              st_nx = SQ_WAIT;
            SQ_WAIT:   if (zeroize) st_nx = SQ_IDLE;
            default:                st_nx = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= SQ_IDLE;
        else     st <= st_nx;
    end

    always_comb begin
        eng_start = (st == SQ_LAUNCH);
        busy      = (st != SQ_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst)          done <= 1'b0;
        else if (zeroize) done <= 1'b1;
        else if (launch)  done <= 1'b0;
    end

    // R3
    start_single_chk: assert property (@(posedge clk) disable iff (rst)
        eng_start |=> !eng_start);
    // R3
    start_loaded_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(eng_start) |-> $past(all_loaded));
    // R5
    wait_release_chk: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_WAIT && zeroize) |=> (!busy && done));
endmodule

// File: rtl/hscrub_msgfile.sv
module hscrub_msgfile #(
    parameter int DATA_W    = 32,
    parameter int NUM_WORDS = 16,
    parameter int IDX_W     = 5,
    localparam int BYTES    = DATA_W / 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic [BYTES-1:0]            wr_strb,
    input  logic                        zeroize,
    input  logic                        busy,
    output logic [NUM_WORDS*DATA_W-1:0] words_flat,
    output logic                        all_loaded
);
    logic [DATA_W-1:0]    word_q [NUM_WORDS];
    logic [NUM_WORDS-1:0] loaded;

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst || zeroize) begin
                word_q[g] <= '0;
                loaded[g] <= 1'b0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                for (int b = 0; b < BYTES; b++) begin
                    if (wr_strb[b]) word_q[g][b*8 +: 8] <= wr_data[b*8 +: 8];
                end
                loaded[g] <= 1'b1;
            end
        end
        assign words_flat[g*DATA_W +: DATA_W] = word_q[g];
    end

    assign all_loaded = &loaded;

    // R6
    scrub_clear_chk: assert property (@(posedge clk) disable iff (rst)
        zeroize |=> (words_flat == '0 && !all_loaded));
    // R7
    zero_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (zeroize && wr_en) |=> (words_flat == '0));
    // R8
    busy_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !zeroize) |=> $stable(words_flat));
endmodule

// File: rtl/hscrub_bank.sv
module hscrub_bank
    import hscrub_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 7,
    parameter int NUM_WORDS = 16,
    localparam int IDX_W    = ADDR_W - 2,
    localparam int BYTES    = DATA_W / 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        periph_rst,
    input  logic [ADDR_W-1:0]           s_awaddr,
    input  logic                        s_awvalid,
    output logic                        s_awready,
    input  logic [DATA_W-1:0]           s_wdata,
    input  logic [BYTES-1:0]            s_wstrb,
    input  logic                        s_wvalid,
    output logic                        s_wready,
    output logic [1:0]                  s_bresp,
    output logic                        s_bvalid,
    input  logic                        s_bready,
    input  logic [ADDR_W-1:0]           s_araddr,
    input  logic                        s_arvalid,
    output logic                        s_arready,
    output logic [DATA_W-1:0]           s_rdata,
    output logic [1:0]                  s_rresp,
    output logic                        s_rvalid,
    input  logic                        s_rready,
    output logic [NUM_WORDS*DATA_W-1:0] eng_block,
    output logic                        eng_start,
    input  logic                        eng_result_valid
);
    localparam logic [IDX_W-1:0] CTRL_IDX = IDX_W'(NUM_WORDS);
    localparam logic [IDX_W-1:0] STAT_IDX = IDX_W'(NUM_WORDS + 1);

    logic                        rst_any, wr_fire, busy, done, zeroize, all_loaded;
    logic [IDX_W-1:0]            wr_idx, rd_idx;
    logic [DATA_W-1:0]           rd_word;
    logic [NUM_WORDS*DATA_W-1:0] words_flat;

    assign rst_any = !rst_n || periph_rst;

    hscrub_axil_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)) u_port (
        .clk(clk), .rst(rst_any),
        .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
        .wvalid(s_wvalid), .wready(s_wready),
        .bresp(s_bresp), .bvalid(s_bvalid), .bready(s_bready),
        .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
        .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(s_rready),
        .rd_word(rd_word), .wr_fire(wr_fire), .wr_idx(wr_idx), .rd_idx(rd_idx)
    );

    hscrub_seq u_seq (
        .clk(clk), .rst(rst_any),
        .ctrl_go(wr_fire && wr_idx == CTRL_IDX && s_wdata[0]),
        .all_loaded(all_loaded), .res_valid(eng_result_valid),
        .eng_start(eng_start), .busy(busy), .done(done), .zeroize(zeroize)
    );

    hscrub_msgfile #(.DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_file (
        .clk(clk), .rst(rst_any),
        .wr_en(wr_fire && wr_idx < CTRL_IDX && !busy),
        .wr_idx(wr_idx), .wr_data(s_wdata), .wr_strb(s_wstrb),
        .zeroize(zeroize), .busy(busy),
        .words_flat(words_flat), .all_loaded(all_loaded)
    );

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_WORDS; i++) begin
            if (rd_idx == IDX_W'(i)) rd_word = words_flat[i*DATA_W +: DATA_W];
        end
        if (rd_idx == STAT_IDX) rd_word = {{(DATA_W-3){1'b0}}, all_loaded, done, busy};
    end

    assign eng_block = busy ? words_flat : '0;
endmodule

// File: tb/tb_hscrub_bank.sv
`timescale 1ns/1ps
module tb_hscrub_bank;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0, prst = 1'b0;
    logic [6:0]   awaddr = '0, araddr = '0;
    logic         awv = 1'b0, wv = 1'b0, bready = 1'b1, arv = 1'b0, rready = 1'b1;
    logic [31:0]  wdata = '0;
    logic [3:0]   wstrb = '0;
    logic         rv = 1'b0;
    logic         awready, wready, bvalid, arready, rvalid, eng_start;
    logic [1:0]   bresp, rresp;
    logic [31:0]  rdata;
    logic [511:0] eng_block;

    int errors = 0, checks = 0;

    always #4 clk = ~clk;

    hscrub_bank dut (
        .clk(clk), .rst_n(rst_n), .periph_rst(prst),
        .s_awaddr(awaddr), .s_awvalid(awv), .s_awready(awready),
        .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wv), .s_wready(wready),
        .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
        .s_araddr(araddr), .s_arvalid(arv), .s_arready(arready),
        .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
        .eng_block(eng_block), .eng_start(eng_start), .eng_result_valid(rv)
    );

    // behavioural reference model
    logic [31:0] mw [16];
    logic [15:0] mload;
    int          mst;
    bit          mdone, mprev, mbv, mrv, started;
    logic [1:0]  mbr, mrr;
    logic [31:0] mrd;

    always @(posedge clk) begin : model
        bit rise, wacc, racc, isbusy, go, wmap, rmap;
        int wi, ri;
        started = 1;
        if (!rst_n || prst) begin
            foreach (mw[k]) mw[k] = '0;
            mload = '0; mst = 0; mdone = 0; mprev = 0;
            mbv = 0; mbr = 0; mrv = 0; mrd = '0; mrr = 0;
        end else begin
            rise   = rv && !mprev;
            mprev  = rv;
            wacc   = awv && wv && !mbv;
            racc   = arv && !mrv;
            wi     = int'(awaddr) / 4;
            ri     = int'(araddr) / 4;
            wmap   = (awaddr[1:0] == 0) && wi <= 16;
            rmap   = (araddr[1:0] == 0) && ri <= 17;
            isbusy = (mst != 0);
            if (racc) begin
                mrv = 1;
                mrr = rmap ? 2'b00 : 2'b10;
                if (!rmap || ri == 16) mrd = '0;
                else if (ri == 17)     mrd = {29'd0, &mload, mdone, isbusy};
                else                   mrd = mw[ri];
            end else if (rready) mrv = 0;
            if (wacc) begin
                mbv = 1;
                mbr = wmap ? 2'b00 : 2'b10;
            end else if (bready) mbv = 0;
            go = wacc && wmap && wi == 16 && wdata[0] && mst == 0 && (&mload) && !rise;
            case (mst)
                0: if (go) mst = 1;
                1: mst = 2;
                default: if (rise) mst = 0;
            endcase
            if (rise) mdone = 1;
            else if (go) mdone = 0;
            if (rise) begin
                foreach (mw[k]) mw[k] = '0;
                mload = '0;
            end else if (wacc && wmap && wi < 16 && !isbusy) begin
                for (int b = 0; b < 4; b++) if (wstrb[b]) mw[wi][b*8 +: 8] = wdata[b*8 +: 8];
                mload[wi] = 1'b1;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin : compare
        logic [511:0] eb;
        if (started && rst_n && !prst) begin
            for (int k = 0; k < 16; k++) eb[k*32 +: 32] = (mst != 0) ? mw[k] : 32'd0;
            chk("R3 start strobe", {31'd0, eng_start}, {31'd0, mst == 1});
            checks++;
            if (eng_block !== eb) begin
                errors++;
                $display("FAIL R4 block: actual %h expected %h", eng_block, eb);
            end
            chk("R10 bvalid", {31'd0, bvalid}, {31'd0, mbv});
            if (mbv) chk("R10 bresp", {30'd0, bresp}, {30'd0, mbr});
            chk("R10 rvalid", {31'd0, rvalid}, {31'd0, mrv});
            if (mrv) begin
                chk("R10 rdata", rdata, mrd);
                chk("R10 rresp", {30'd0, rresp}, {30'd0, mrr});
            end
        end
    end

    task automatic wr(input logic [6:0] a, input logic [31:0] d, input logic [3:0] s,
                      output logic [1:0] resp);
        @(negedge clk);
        awaddr = a; wdata = d; wstrb = s; awv = 1; wv = 1;
        #1;
        while (!awready) begin @(negedge clk); #1; end
        @(negedge clk);
        awv = 0; wv = 0;
        resp = bresp;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d, output logic [1:0] resp);
        @(negedge clk);
        araddr = a; arv = 1;
        #1;
        while (!arready) begin @(negedge clk); #1; end
        @(negedge clk);
        arv = 0;
        d = rdata; resp = rresp;
    endtask

    task automatic pulse_valid();
        @(negedge clk); rv = 1;
        repeat (2) @(negedge clk);
        rv = 0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : stim
        logic [31:0] d;
        logic [1:0]  r;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R2 reset state
        rd(7'h44, d, r); chk("R2 status after reset", d, 32'd0);
        rd(7'h0C, d, r); chk("R1 word3 after reset", d, 32'd0);
        // R3 go with only 15 words loaded is refused
        for (int k = 0; k < 15; k++) begin
            wr(7'(k*4), 32'hA500_0000 + k, 4'hF, r);
        end
        wr(7'h40, 32'd1, 4'hF, r); chk("R3 early go OKAY", {30'd0, r}, 32'd0);
        repeat (2) @(negedge clk);
        rd(7'h44, d, r); chk("R3 early go not busy", d, 32'd0);
        wr(7'h3C, 32'hA500_000F, 4'hF, r);
        // R1 readback and byte strobes
        rd(7'h08, d, r); chk("R1 word2 readback", d, 32'hA500_0002);
        wr(7'h14, 32'h1122_3344, 4'hF, r);
        wr(7'h14, 32'hFFFF_FFFF, 4'b0101, r);
        rd(7'h14, d, r); chk("R1 strobe merge", d, 32'h11FF_33FF);
        rd(7'h44, d, r); chk("R5 loaded flag", d, 32'd4);
        rd(7'h40, d, r); chk("R9 control reads zero", {d[29:0], r}, 32'd0);
        // R3 start
        wr(7'h40, 32'd1, 4'hF, r);
        rd(7'h44, d, r); chk("R5 busy", d, 32'd5);
        // R8 writes while busy
        wr(7'h08, 32'hDEAD_BEEF, 4'hF, r); chk("R8 busy write OKAY", {30'd0, r}, 32'd0);
        wr(7'h40, 32'd1, 4'hF, r);
        rd(7'h08, d, r); chk("R8 word2 unchanged", d, 32'hA500_0002);
        // R6 wipe
        pulse_valid();
        for (int k = 0; k < 16; k++) begin
            rd(7'(k*4), d, r); chk("R6 word zero after wipe", d, 32'd0);
        end
        rd(7'h44, d, r); chk("R6 done after wipe", d, 32'd2);
        // R9 unmapped and misaligned accesses
        rd(7'h50, d, r); chk("R9 unmapped read", {d[29:0], r}, 32'd2);
        wr(7'h04, 32'h5555_5555, 4'hF, r);
        wr(7'h49, 32'h1, 4'hF, r); chk("R9 unmapped write SLVERR", {30'd0, r}, 32'd2);
        wr(7'h05, 32'h7777_7777, 4'hF, r); chk("R9 misaligned SLVERR", {30'd0, r}, 32'd2);
        wr(7'h44, 32'h7, 4'hF, r); chk("R9 status write SLVERR", {30'd0, r}, 32'd2);
        rd(7'h04, d, r); chk("R9 word1 untouched", d, 32'h5555_5555);
        rd(7'h44, d, r); chk("R9 status untouched", d, 32'd2);
        // R7 wipe beats same-cycle write
        @(negedge clk);
        awaddr = 7'h1C; wdata = 32'h1234_5678; wstrb = 4'hF; awv = 1; wv = 1; rv = 1;
        @(negedge clk);
        awv = 0; wv = 0;
        @(negedge clk); rv = 0;
        rd(7'h1C, d, r); chk("R7 word7 zero", d, 32'd0);
        rd(7'h04, d, r); chk("R7 word1 cleared", d, 32'd0);
        // R10 response held while bready low
        bready = 0;
        @(negedge clk);
        awaddr = 7'h20; wdata = 32'h0BAD_F00D; wstrb = 4'hF; awv = 1; wv = 1;
        @(negedge clk);
        awv = 0; wv = 0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); chk("R10 bvalid held", {31'd0, bvalid}, 32'd1);
        end
        bready = 1;
        // second hash with fresh data
        for (int k = 0; k < 16; k++) wr(7'(k*4), 32'hC0DE_0000 ^ k, 4'hF, r);
        wr(7'h40, 32'd1, 4'hF, r);
        repeat (3) @(negedge clk);
        pulse_valid();
        rd(7'h30, d, r); chk("R6 second wipe word12", d, 32'd0);
        // R2 peripheral reset and global reset
        wr(7'h10, 32'hAAAA_AAAA, 4'hF, r);
        @(negedge clk); prst = 1;
        @(negedge clk); prst = 0;
        rd(7'h10, d, r); chk("R2 periph reset clears", d, 32'd0);
        rd(7'h44, d, r); chk("R2 periph reset status", d, 32'd0);
        wr(7'h24, 32'hBBBB_BBBB, 4'hF, r);
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        rd(7'h24, d, r); chk("R2 global reset clears", d, 32'd0);
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule